// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Pinned Slots

This block is a small, fully associative address translation buffer. Every entry maps a naturally aligned virtual range of 4 KiB × 4^k onto a physical base and carries an opaque attribute byte. A lookup port compares an address against all valid entries at once. One clock later it returns either a hit, with the slot index, the translated physical address and the attributes, or a miss.

The slots form two groups. The lowest `N_PIN` slots are pinned and hold long-lived block mappings. Only commands that name a slot explicitly, and the pinned purge-all command, can change them. The remaining slots are dynamic. An insert places a new mapping in the lowest free dynamic slot. When no dynamic slot is free, a round-robin pointer chooses the victim.

Commands arrive on a valid/ready port and finish with a one-cycle response pulse. Every command that can touch several slots walks the table one slot per cycle, and ready stays low until the walk ends. These commands are insert, range purge and both purge-all commands. A two-step insert is also provided. Its address step reserves a slot with an invalid entry. Its attribute step then validates that entry, but only when the step's address falls inside the reserved range.

Top module: `tlbr_top`

## Requirements
- R1: A lookup request gives exactly one of `lk_hit` or `lk_miss` one cycle later. A hit reports the matching slot, the attributes and the physical address. The physical address is the PPN shifted up by 12 with the in-range bits cleared, OR'ed with the in-range bits of the address. When several entries match, the lowest slot index wins.
- R2: For an insert, the size code k is `cmd_data[3:0]` and the PPN is `cmd_data[24:5]`. The range is 4 KiB << 2k. Its base is `cmd_addr` aligned down to that size, and its last address is base + size − 1.
- R3: Before an insert or address step installs its entry, every valid dynamic entry that overlaps the new range is removed.
- R4: Range purges, insert overlap removal, replacement and the dynamic purge-all never remove a pinned entry. Only pinned insert, pinned purge and pinned purge-all change one.
- R5: An insert uses the lowest-index free dynamic slot when one exists.
- R6: With no free dynamic slot, the victim is the slot at the round-robin pointer, and the pointer then moves to the next slot. A pointer inside the pinned group or past the last slot restarts at slot `N_PIN`.
- R7: Dynamic purge-all (op 4) clears every dynamic slot, returns the pointer to slot `N_PIN` and cancels a pending two-step insert. Pinned entries stay.
- R8: Pinned insert (op 5) writes slot `cmd_slot` from the same fields as R2, with attribute bit 0 (dirty) forced to 1 and bit 1 (trap) forced to 0.
- R9: A pinned insert or pinned purge with `cmd_slot >= N_PIN` raises `rsp_bad_slot` and changes no entry.
- R10: Range purge (op 3) takes the count c from `cmd_addr[3:0]` and removes the dynamic entries that overlap the 4 KiB << 2c range at the aligned address. c = 0 covers a single page.
- R11: The address step (op 1) installs a single-page entry with PPN `cmd_data[24:5]` that does not match lookups. The attribute step (op 2) validates it with `cmd_attr` when `cmd_addr` lies within its range.
- R12: An attribute step with no pending entry, or with an address outside the pending range, leaves the table unchanged, clears the pending state and raises `rsp_seq_err`.
- R13: Ops 0, 1, 3, 4 and 7 hold `cmd_ready` low while they walk all `N_ENT` slots, one per cycle. Ops 2, 5 and 6 answer on the cycle after acceptance. Op codes: 0 insert, 1 address step, 2 attribute step, 3 range purge, 4 dynamic purge-all, 5 pinned insert, 6 pinned purge, 7 pinned purge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | VA_W | Virtual address; holds the count in bits 3:0 for a range purge |
| cmd_data | input | 25 | Size code in bits 3:0, PPN in bits 24:5 |
| cmd_attr | input | ATTR_W | Attribute byte |
| cmd_slot | input | IDX_W | Slot for pinned commands |
| rsp_valid | output | 1 | Command completed |
| rsp_bad_slot | output | 1 | Slot index outside the pinned group |
| rsp_seq_err | output | 1 | Attribute step rejected |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | VA_W | Lookup address |
| lk_hit | output | 1 | Lookup matched |
| lk_miss | output | 1 | Lookup found no entry |
| lk_idx | output | IDX_W | Matching slot |
| lk_phys | output | PA_W | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the matching entry |

## Verification
A corrupted valid bit, bound or pointer shows up on the very next lookup of an affected address. It appears as a wrong hit/miss, a wrong slot index or a shifted physical address, one cycle after the request. A wrong round-robin pointer or free-slot choice shows in the `lk_idx` of the entry that was just inserted. A lost pinned entry shows on its first lookup after any purge. The bench sweeps both range boundaries for several size codes and walks a full wrap of the replacement pointer. It checks each of these with values derived arithmetically.

// File: rtl/tlbr_pkg.sv
// Shared definitions for the range-matched translation buffer.
// Assumes a 3-bit operation field and a fixed attribute bit placement.
package tlbr_pkg;
    typedef enum logic [2:0] {
        OP_INSERT        = 3'd0,
        OP_ADDR_STEP     = 3'd1,
        OP_ATTR_STEP     = 3'd2,
        OP_PURGE_RANGE   = 3'd3,
        OP_PURGE_DYN     = 3'd4,
        OP_PIN_INSERT    = 3'd5,
        OP_PIN_PURGE     = 3'd6,
        OP_PIN_PURGE_ALL = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_INSTALL
    } st_e;

    localparam int DIRTY_BIT = 0;
    localparam int TRAP_BIT  = 1;
endpackage

// File: rtl/tlbr_match.sv
// Parallel range comparator: flags every valid entry whose [base, last]
// contains the address and reports the lowest matching index.
// Assumes base <= last for every valid entry.
module tlbr_match #(
    parameter int N_ENT = 8,
    parameter int VA_W  = 32,
    parameter int IDX_W = 3
) (
    input  logic [N_ENT-1:0] valid,
    input  logic [VA_W-1:0]  base [N_ENT],
    input  logic [VA_W-1:0]  last [N_ENT],
    input  logic [VA_W-1:0]  addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [N_ENT-1:0] m;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign m[g] = valid[g] && (addr >= base[g]) && (addr <= last[g]);
    end

    // Lowest-index priority select over the match vector
    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (m[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |m;
endmodule

// File: rtl/tlbr_alloc.sv
// Slot allocator for the dynamic group: picks the lowest free dynamic slot,
// otherwise the round-robin victim. Assumes N_PIN < N_ENT.
module tlbr_alloc #(
    parameter int N_ENT = 8,
    parameter int N_PIN = 2,
    parameter int IDX_W = 3
) (
    input  logic [N_ENT-1:0] taken,
    input  logic [IDX_W:0]   rr,
    output logic [IDX_W-1:0] pick,
    output logic             is_victim
);
    logic             found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W:0]   rr_eff;

    // Lowest free slot at or above the pinned group
    always_comb begin
        found    = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= N_PIN; i--) begin
            if (!taken[i]) begin
                found    = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Pointer restarts at the first dynamic slot when out of the dynamic group
    always_comb begin
        if (int'(rr) < N_PIN || int'(rr) >= N_ENT) rr_eff = (IDX_W+1)'(N_PIN);
        else                                       rr_eff = rr;
    end

    assign pick      = found ? free_idx : rr_eff[IDX_W-1:0];
    assign is_victim = !found;
endmodule

// File: rtl/tlbr_top.sv
// Range-matched translation buffer with pinned low slots.
// Commands on a valid/ready port; multi-slot commands walk one slot per
// cycle with ready low. Lookups are answered one cycle after the request.
// Assumes N_ENT is a power of two and 0 < N_PIN < N_ENT.
module tlbr_top
    import tlbr_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int N_ENT     = 8,
    parameter int N_PIN     = 2,
    parameter int PAGE_BITS = 12,
    parameter int ATTR_W    = 8,
    parameter int PPN_LSB   = 5,
    parameter int PPN_W     = 20,
    localparam int IDX_W    = $clog2(N_ENT),
    localparam int DATA_W   = PPN_LSB + PPN_W,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ATTR_W-1:0] cmd_attr,
    input  logic [IDX_W-1:0]  cmd_slot,
    output logic              rsp_valid,
    output logic              rsp_bad_slot,
    output logic              rsp_seq_err,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PA_W-1:0]   lk_phys,
    output logic [ATTR_W-1:0] lk_attr
);
    // Entry storage
    logic [N_ENT-1:0]  ent_v;
    logic [VA_W-1:0]   ent_base [N_ENT];
    logic [VA_W-1:0]   ent_last [N_ENT];
    logic [PPN_W-1:0]  ent_ppn  [N_ENT];
    logic [ATTR_W-1:0] ent_attr [N_ENT];

    // Sequencer state and latched command
    st_e               state;
    op_e               c_op;
    logic [VA_W-1:0]   c_base, c_last;
    logic [PPN_W-1:0]  c_ppn;
    logic [ATTR_W-1:0] c_attr;
    logic [IDX_W-1:0]  scan_idx;
    logic [IDX_W:0]    rr;
    logic              pend;
    logic [IDX_W-1:0]  pend_idx;

    // Decoded command fields
    op_e               op_in;
    logic [3:0]        cmd_k;
    logic [VA_W-1:0]   cmd_low, cmd_base, cmd_lastv;
    logic [PPN_W-1:0]  cmd_ppn;
    logic [ATTR_W-1:0] pin_attr;
    logic              fire, slot_ok, pend_hit;
    logic              s_ovl, s_dyn, s_clr;
    logic [N_ENT-1:0]  taken;
    logic [IDX_W-1:0]  pick, inst_slot;
    logic              is_victim, reuse_pend;
    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic [VA_W-1:0]   m_low;
    logic [PA_W-1:0]   m_phys;
    logic              unused_bit;

    // Low-bit mask of a 4 KiB << 2k range
    function automatic logic [VA_W-1:0] low_span(input logic [3:0] k);
        logic [VA_W-1:0] r;
        for (int i = 0; i < VA_W; i++) r[i] = (i < PAGE_BITS + 2 * int'(k));
        return r;
    endfunction

    assign unused_bit = cmd_data[4];
    assign op_in      = op_e'(cmd_op);
    assign cmd_ready  = (state == ST_IDLE);
    assign fire       = cmd_valid && cmd_ready;
    assign slot_ok    = int'(cmd_slot) < N_PIN;

    // Decode size code, aligned range and PPN of the offered command
    always_comb begin
        if (op_in == OP_PURGE_RANGE)    cmd_k = cmd_addr[3:0];
        else if (op_in == OP_ADDR_STEP) cmd_k = 4'd0;
        else                            cmd_k = cmd_data[3:0];
        cmd_low   = low_span(cmd_k);
        cmd_base  = cmd_addr & ~cmd_low;
        cmd_lastv = cmd_base | cmd_low;
        cmd_ppn   = cmd_data[PPN_LSB +: PPN_W];
        pin_attr  = cmd_attr;
        pin_attr[DIRTY_BIT] = 1'b1;
        pin_attr[TRAP_BIT]  = 1'b0;
        pend_hit  = pend && (cmd_addr >= ent_base[pend_idx])
                         && (cmd_addr <= ent_last[pend_idx]);
    end

    // Clear decision for the slot being walked
    always_comb begin
        s_ovl = (ent_base[scan_idx] <= c_last) && (c_base <= ent_last[scan_idx]);
        s_dyn = int'(scan_idx) >= N_PIN;
        case (c_op)
            OP_INSERT, OP_ADDR_STEP, OP_PURGE_RANGE: s_clr = s_dyn && s_ovl;
            OP_PURGE_DYN:                            s_clr = s_dyn;
            OP_PIN_PURGE_ALL:                        s_clr = !s_dyn;
            default:                                 s_clr = 1'b0;
        endcase
        s_clr = s_clr && ent_v[scan_idx];
    end

    // A pending entry is invalid but reserved: never treat it as free
    always_comb begin
        taken = ent_v;
        if (pend) taken[pend_idx] = 1'b1;
    end

    tlbr_alloc #(.N_ENT(N_ENT), .N_PIN(N_PIN), .IDX_W(IDX_W)) u_alloc (
        .taken(taken), .rr(rr), .pick(pick), .is_victim(is_victim)
    );

    assign reuse_pend = (c_op == OP_ADDR_STEP) && pend;
    assign inst_slot  = reuse_pend ? pend_idx : pick;

    // Command sequencer and table writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            ent_v        <= '0;
            scan_idx     <= '0;
            rr           <= (IDX_W+1)'(N_PIN);
            pend         <= 1'b0;
            pend_idx     <= '0;
            c_op         <= OP_INSERT;
            c_base       <= '0;
            c_last       <= '0;
            c_ppn        <= '0;
            c_attr       <= '0;
            rsp_valid    <= 1'b0;
            rsp_bad_slot <= 1'b0;
            rsp_seq_err  <= 1'b0;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_bad_slot <= 1'b0;
            rsp_seq_err  <= 1'b0;
            case (state)
                ST_IDLE: if (fire) begin
                    c_op     <= op_in;
                    c_base   <= cmd_base;
                    c_last   <= cmd_lastv;
                    c_ppn    <= cmd_ppn;
                    c_attr   <= cmd_attr;
                    scan_idx <= '0;
                    case (op_in)
                        OP_ATTR_STEP: begin
                            pend      <= 1'b0;
                            rsp_valid <= 1'b1;
                            if (pend_hit) begin
                                ent_v[pend_idx]    <= 1'b1;
                                ent_attr[pend_idx] <= cmd_attr;
                            end else begin
                                rsp_seq_err <= 1'b1;
                            end
                        end
                        OP_PIN_INSERT: begin
                            rsp_valid <= 1'b1;
                            if (slot_ok) begin
                                ent_v[cmd_slot]    <= 1'b1;
                                ent_base[cmd_slot] <= cmd_base;
                                ent_last[cmd_slot] <= cmd_lastv;
                                ent_ppn[cmd_slot]  <= cmd_ppn;
                                ent_attr[cmd_slot] <= pin_attr;
                            end else begin
                                rsp_bad_slot <= 1'b1;
                            end
                        end
                        OP_PIN_PURGE: begin
                            rsp_valid <= 1'b1;
                            if (slot_ok) ent_v[cmd_slot] <= 1'b0;
                            else         rsp_bad_slot    <= 1'b1;
                        end
                        OP_PURGE_DYN: begin
                            pend  <= 1'b0;
                            rr    <= (IDX_W+1)'(N_PIN);
                            state <= ST_SCAN;
                        end
                        default: state <= ST_SCAN;
                    endcase
                end
                ST_SCAN: begin
                    if (s_clr) ent_v[scan_idx] <= 1'b0;
                    if (scan_idx == IDX_W'(N_ENT - 1)) begin
                        if (c_op == OP_INSERT || c_op == OP_ADDR_STEP) begin
                            state <= ST_INSTALL;
                        end else begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                        end
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                ST_INSTALL: begin
                    ent_v[inst_slot]    <= (c_op == OP_INSERT);
                    ent_base[inst_slot] <= c_base;
                    ent_last[inst_slot] <= c_last;
                    ent_ppn[inst_slot]  <= c_ppn;
                    ent_attr[inst_slot] <= c_attr;
                    if (c_op == OP_ADDR_STEP) begin
                        pend     <= 1'b1;
                        pend_idx <= inst_slot;
                    end else if (pend && inst_slot == pend_idx) begin
                        pend <= 1'b0;
                    end
                    if (is_victim && !reuse_pend) rr <= (IDX_W+1)'(pick) + 1'b1;
                    state     <= ST_IDLE;
                    rsp_valid <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    tlbr_match #(.N_ENT(N_ENT), .VA_W(VA_W), .IDX_W(IDX_W)) u_match (
        .valid(ent_v), .base(ent_base), .last(ent_last),
        .addr(lk_addr), .hit(m_hit), .idx(m_idx)
    );

    // Physical address: aligned PPN base plus the in-range offset
    always_comb begin
        m_low  = ent_last[m_idx] ^ ent_base[m_idx];
        m_phys = ({ent_ppn[m_idx], {PAGE_BITS{1'b0}}} & ~PA_W'(m_low))
               | (PA_W'(lk_addr) & PA_W'(m_low));
    end

    // Registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_miss <= 1'b0;
            lk_idx  <= '0;
            lk_phys <= '0;
            lk_attr <= '0;
        end else begin
            lk_hit  <= lk_req && m_hit;
            lk_miss <= lk_req && !m_hit;
            lk_idx  <= m_hit ? m_idx : '0;
            lk_phys <= m_hit ? m_phys : '0;
            lk_attr <= m_hit ? ent_attr[m_idx] : '0;
        end
    end
endmodule

// File: rtl/tlbr_chk.sv
// Protocol and pinned-slot checker for tlbr_top, attached by bind.
// Assumes it sees the pinned valid bits of the table.
module tlbr_chk #(
    parameter int N_ENT = 8,
    parameter int N_PIN = 2,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_slot,
    input logic             rsp_valid,
    input logic             rsp_bad_slot,
    input logic             lk_req,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [N_PIN-1:0] pin_v
);
    logic fire, pin_walk, pin_touch;

    assign fire      = cmd_valid && cmd_ready;
    assign pin_touch = (fire && (cmd_op == 3'd5 || cmd_op == 3'd6 || cmd_op == 3'd7))
                     || pin_walk;

    // Tracks an accepted pinned purge-all until the port is ready again
    always_ff @(posedge clk) begin
        if (!rst_n)                        pin_walk <= 1'b0;
        else if (fire && cmd_op == 3'd7)   pin_walk <= 1'b1;
        else if (cmd_ready)                pin_walk <= 1'b0;
    end

    assert_lookup_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_hit != lk_miss));

    assert_lookup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !(lk_hit || lk_miss));

    assert_pinned_only_by_pin_ops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_v) |-> $past(pin_touch));

    assert_bad_slot_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cmd_op == 3'd5 || cmd_op == 3'd6) && int'(cmd_slot) >= N_PIN)
        |=> (rsp_valid && rsp_bad_slot));

    assert_walk_holds_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cmd_op == 3'd0 || cmd_op == 3'd3 || cmd_op == 3'd4)) |=> !cmd_ready);

    assert_single_cycle_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cmd_op == 3'd2 || cmd_op == 3'd5 || cmd_op == 3'd6))
        |=> (rsp_valid && cmd_ready));
endmodule

bind tlbr_top tlbr_chk #(.N_ENT(N_ENT), .N_PIN(N_PIN), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .rsp_valid(rsp_valid),
    .rsp_bad_slot(rsp_bad_slot), .lk_req(lk_req), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .pin_v(ent_v[N_PIN-1:0])
);

// File: tb/tb_tlbr_top.sv
`timescale 1ns/1ps
module tb_tlbr_top;
    localparam int N_ENT = 8;
    localparam int N_PIN = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 0;
    logic [31:0] cmd_addr = 0;
    logic [24:0] cmd_data = 0;
    logic [7:0]  cmd_attr = 0;
    logic [2:0]  cmd_slot = 0;
    logic        rsp_valid, rsp_bad_slot, rsp_seq_err;
    logic        lk_req = 0;
    logic [31:0] lk_addr = 0;
    logic        lk_hit, lk_miss;
    logic [2:0]  lk_idx;
    logic [31:0] lk_phys;
    logic [7:0]  lk_attr;

    int n_chk = 0;
    int n_fail = 0;
    logic got_bad, got_seq;

    always #4 clk = ~clk;

    tlbr_top dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] word(input int k, input int ppn);
        return 25'((ppn << 5) | k);
    endfunction

    // Issue one command and wait for its response pulse
    task automatic cmd(input int op, input logic [31:0] a, input logic [24:0] d,
                       input logic [7:0] at, input int slot);
        int guard;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
        cmd_attr = at; cmd_slot = 3'(slot);
        @(negedge clk);
        cmd_valid = 0;
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        got_bad = rsp_bad_slot;
        got_seq = rsp_seq_err;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        lk_req = 1; lk_addr = a;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic exp_hit(input string tag, input logic [31:0] a,
                           input int idx, input logic [31:0] phys);
        look(a);
        chk(lk_hit && !lk_miss, {tag, " hit"}, lk_hit, 1);
        chk(lk_idx == 3'(idx), {tag, " idx"}, lk_idx, idx);
        chk(lk_phys == phys, {tag, " phys"}, lk_phys, phys);
    endtask

    task automatic exp_miss(input string tag, input logic [31:0] a);
        look(a);
        chk(lk_miss && !lk_hit, {tag, " miss"}, lk_hit, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // Reset state
        chk(cmd_ready == 1, "R13 ready after reset", cmd_ready, 1);
        exp_miss("R1 empty table", 32'h0000_0000);

        // R2: single page, boundaries
        cmd(0, 32'h0001_2345, word(0, 'h55), 8'h3C, 0);
        for (int off = 0; off < 4096; off += 1365)
            exp_hit("R2 page sweep", 32'h0001_2000 + off, 2, 32'h0005_5000 + off);
        exp_hit("R2 page last", 32'h0001_2FFF, 2, 32'h0005_5FFF);
        exp_miss("R2 page after end", 32'h0001_3000);
        exp_miss("R2 page before base", 32'h0001_1FFF);

        // R2: k=2 gives 64 KiB, PPN aligned to size
        cmd(0, 32'h0013_7000, word(2, 'h123), 8'h00, 0);
        exp_hit("R2 k2 base", 32'h0013_0000, 3, 32'h0012_0000);
        exp_hit("R2 k2 last", 32'h0013_FFFF, 3, 32'h0012_FFFF);
        exp_miss("R2 k2 past end", 32'h0014_0000);
        exp_miss("R2 k2 below base", 32'h0012_FFFF);

        // R3: overlapping insert removes the large entry
        cmd(0, 32'h0013_1000, word(0, 'h99), 8'h00, 0);
        exp_miss("R3 overlapped gone", 32'h0013_5000);
        exp_hit("R3 new entry", 32'h0013_1010, 3, 32'h0009_9010);

        // R13: purge-all walk keeps ready low for N_ENT cycles
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd4;
        @(negedge clk);
        cmd_valid = 0;
        chk(cmd_ready == 0, "R13 ready low in walk", cmd_ready, 0);
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == N_ENT, "R13 walk length", n, N_ENT);
        exp_miss("R7 dynamic cleared", 32'h0001_2000);

        // R5: free slots fill lowest first
        for (int i = 0; i < N_ENT - N_PIN; i++) begin
            cmd(0, 32'h0020_0000 + i * 32'h1000, word(0, 'h100 + i), 8'h00, 0);
            exp_hit("R5 free slot order", 32'h0020_0000 + i * 32'h1000, N_PIN + i,
                    32'h0010_0000 + i * 32'h1000);
        end
        // R6: round-robin victims with wrap
        for (int i = 0; i < N_ENT - N_PIN + 1; i++) begin
            cmd(0, 32'h0030_0000 + i * 32'h1000, word(0, 'h200 + i), 8'h00, 0);
            exp_hit("R6 victim order", 32'h0030_0000 + i * 32'h1000,
                    N_PIN + (i % (N_ENT - N_PIN)), 32'h0020_0000 + i * 32'h1000);
        end
        exp_miss("R6 evicted entry", 32'h0020_0000);

        // R8/R9: pinned inserts
        cmd(4, 0, 0, 0, 0);
        cmd(5, 32'h0040_0000, word(1, 'h400), 8'hA2, 0);
        chk(got_bad == 0, "R9 slot 0 accepted", got_bad, 0);
        exp_hit("R8 pinned k1", 32'h0040_3FFF, 0, 32'h0040_3FFF);
        chk(lk_attr == 8'hA1, "R8 forced dirty/trap", lk_attr, 8'hA1);
        cmd(5, 32'h0050_0000, word(0, 'h500), 8'h00, 1);
        exp_hit("R8 pinned slot1", 32'h0050_0004, 1, 32'h0050_0004);
        chk(lk_attr == 8'h01, "R8 forced dirty", lk_attr, 8'h01);
        cmd(5, 32'h0060_0000, word(0, 'h600), 8'h00, 2);
        chk(got_bad == 1, "R9 slot out of range", got_bad, 1);
        exp_miss("R9 no entry written", 32'h0060_0000);
        cmd(6, 0, 0, 0, 7);
        chk(got_bad == 1, "R9 purge slot out of range", got_bad, 1);
        exp_hit("R9 pinned intact", 32'h0040_0000, 0, 32'h0040_0000);

        // R4: pinned entries survive dynamic operations
        cmd(3, 32'h0040_0001, 0, 0, 0);
        exp_hit("R4 survives range purge", 32'h0040_0000, 0, 32'h0040_0000);
        cmd(0, 32'h0040_1000, word(0, 'h700), 8'h00, 0);
        exp_hit("R1 lowest index wins", 32'h0040_1000, 0, 32'h0040_1000);
        exp_hit("R4 survives insert", 32'h0040_2000, 0, 32'h0040_2000);
        cmd(4, 0, 0, 0, 0);
        exp_hit("R7 pinned kept", 32'h0050_0000, 1, 32'h0050_0000);
        cmd(6, 0, 0, 0, 0);
        exp_miss("R4 pinned purge", 32'h0040_0000);
        exp_hit("R4 other pinned kept", 32'h0050_0000, 1, 32'h0050_0000);
        cmd(7, 0, 0, 0, 0);
        exp_miss("R4 pinned purge-all", 32'h0050_0000);

        // R10: range purge counts
        cmd(0, 32'h0080_0000, word(0, 'h800), 8'h00, 0);
        cmd(0, 32'h0080_3000, word(0, 'h803), 8'h00, 0);
        cmd(0, 32'h0080_4000, word(0, 'h804), 8'h00, 0);
        cmd(3, 32'h0080_0001, 0, 0, 0);
        exp_miss("R10 count1 first", 32'h0080_0000);
        exp_miss("R10 count1 last page", 32'h0080_3000);
        look(32'h0080_4000);
        chk(lk_hit == 1, "R10 beyond range kept", lk_hit, 1);
        cmd(0, 32'h0081_0000, word(0, 'h810), 8'h00, 0);
        cmd(0, 32'h0081_1000, word(0, 'h811), 8'h00, 0);
        cmd(3, 32'h0081_0000, 0, 0, 0);
        exp_miss("R10 count0 page", 32'h0081_0000);
        look(32'h0081_1000);
        chk(lk_hit == 1, "R10 count0 neighbour kept", lk_hit, 1);

        // R11/R12: two-step insert
        cmd(4, 0, 0, 0, 0);
        cmd(1, 32'h0090_0000, word(0, 'h77), 8'h00, 0);
        exp_miss("R11 address step invalid", 32'h0090_0000);
        cmd(2, 32'h0090_0ABC, 0, 8'h5C, 0);
        chk(got_seq == 0, "R11 attr step accepted", got_seq, 0);
        exp_hit("R11 validated", 32'h0090_0ABC, 2, 32'h0007_7ABC);
        chk(lk_attr == 8'h5C, "R11 attr", lk_attr, 8'h5C);
        cmd(1, 32'h00A0_0000, word(0, 'h78), 8'h00, 0);
        cmd(2, 32'h00B0_0000, 0, 8'h11, 0);
        chk(got_seq == 1, "R12 address outside", got_seq, 1);
        exp_miss("R12 entry dropped", 32'h00A0_0000);
        cmd(2, 32'h00A0_0000, 0, 8'h11, 0);
        chk(got_seq == 1, "R12 nothing pending", got_seq, 1);
        exp_miss("R12 still dropped", 32'h00A0_0000);
        cmd(1, 32'h00C0_0000, word(0, 'h79), 8'h00, 0);
        cmd(4, 0, 0, 0, 0);
        cmd(2, 32'h00C0_0000, 0, 8'h11, 0);
        chk(got_seq == 1, "R7 pending cancelled", got_seq, 1);
        exp_miss("R7 cancelled entry", 32'h00C0_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule